// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the step engine of a small 8-bit processor with a 16-bit address space. It holds the opcode being executed in an 8-bit instruction register and counts the micro-steps of that opcode with a 4-bit counter. Each step, it joins the opcode, four status flags, two interrupt bits and the step count into an 18-bit microcode address. It looks that address up in an internal table and presents the resulting 48-bit control word to the datapath. Two encoded fields of the word are expanded into one-hot lines: the bus-source field and the write-select field.

The counter moves on the falling clock edge, so a new word settles during the low phase and the datapath latches on the next rising edge. A sequence ends when its word raises the step-clear line. That line clears the counter at once, without a clock edge, so the same low phase already carries the word for step 0. Step 0 is where the microcode places the common fetch, which loads the instruction register from the data bus. A hard reset clears the register and the counter asynchronously, so execution starts at step 0 of opcode 0x00, the soft-reset routine.

The table is a parameter made of rows. Each row has a valid bit, a match value and a care mask over the 18 address bits, plus a 48-bit word. The lowest-numbered row that matches wins. A row can therefore ignore flags, interrupt bits or the step, and unprogrammed addresses fall back to an idle word.

Top module: `useq_top`

## Requirements
- R1: The microcode address is {instruction register (bits 17:10), flags (bits 9:6, where flags[3] is zero, flags[2] overflow, flags[1] negative, flags[0] carry), interrupt inhibit intr[1] (bit 5), interrupt request intr[0] (bit 4), step (bits 3:0)}. Every instruction byte is a whole opcode, so different opcodes at the same step select different rows.
- R2: The step counter increments by one on every falling clock edge unless it is being cleared.
- R3: A word with bit 7 (step clear) set clears the counter immediately. The word for step 0 is then presented in that same low phase.
- R4: On a rising edge, the instruction register loads dataBus when bit 8 (instruction load) of the current word is set. Otherwise it holds its value.
- R5: hardRst clears the instruction register and the step counter asynchronously. While it is high the counter stays at 0, and the output is the word for opcode 0x00, step 0.
- R6: Table row r sits at TABLE[r*85 +: 85] as {valid, match[17:0], care[17:0], word[47:0]}. A row hits when it is valid and the address agrees with match on every care bit. The lowest hitting row supplies the word. A row whose mask omits the flag and interrupt bits (as for opcode 0x00) gives the same word for any flag or interrupt value.
- R7: An address that no row hits yields the idle word: source code 15, write code 0, step clear set, and every other bit clear. The sequence therefore returns to step 0 within the same cycle.
- R8: Bits 3:0 are the bus-source code. A code k from 0 to 14 raises busEn[k] alone. Code 15 raises no enable.
- R9: Bits 6:4 are the write-select code, decoded so that exactly wrSel[code] is high.
- R10: ctlRaw carries the whole 48-bit word unchanged. Raw and decoded outputs follow a step change within the same low phase.
- R11: After step 15, a counter that is not cleared wraps to step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; steps advance on the falling edge, the register loads on the rising edge |
| hardRst | input | 1 | Asynchronous hard reset, active high |
| dataBus | input | 8 | Data bus, source of the opcode byte |
| flags | input | 4 | Status flags: zero, overflow, negative, carry (bit 3 down to bit 0) |
| intr | input | 2 | Interrupt inhibit (bit 1) and interrupt request (bit 0) |
| ctlRaw | output | 48 | Raw control word of the current step |
| busEn | output | 15 | One-hot data-bus source enables |
| wrSel | output | 8 | One-hot write/select lines |

## Verification
A change of step, flags or interrupt bits reaches every output combinationally within the low phase that follows the falling edge. An opcode loaded on a rising edge shows up in the word one falling edge later, at the next step. A hard-reset pulse takes effect at once, with no edge needed. The driver changes inputs half a nanosecond after each rising edge and queues the word expected for that cycle. The monitor samples half a nanosecond before the next rising edge, after the falling edge and after any immediate clear has settled. Because the expected counts are derived this way, a skipped step, an early or missing register load, or a clear that waits for a clock edge all show up as a wrong word in the cycle where they occur.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;
  localparam int OP_W   = 8;
  localparam int FLAG_W = 4;
  localparam int INT_W  = 2;
  localparam int STEP_W = 4;
  localparam int ADDR_W = OP_W + FLAG_W + INT_W + STEP_W;

  localparam int WORD_W = 48;
  localparam int SRC_W  = 4;
  localparam int WRS_W  = 3;

  // word field positions
  localparam int SRC_LSB  = 0;
  localparam int WRS_LSB  = SRC_LSB + SRC_W;
  localparam int CLR_BIT  = WRS_LSB + WRS_W;
  localparam int LOAD_BIT = CLR_BIT + 1;

  // all-ones source code is reserved: nothing drives the bus
  localparam int NUM_SRC = (1 << SRC_W) - 1;
  localparam int NUM_WRS = 1 << WRS_W;
  localparam logic [SRC_W-1:0] SRC_NONE = '1;

  // one table row: {valid, match, care, word}
  localparam int ROW_W = 1 + 2 * ADDR_W + WORD_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] uaddr_t;

  typedef struct packed {
    logic irLoad;
    logic stepClr;
  } strobe_t;

  localparam word_t IDLE_WORD = (word_t'(SRC_NONE) << SRC_LSB) | (word_t'(1) << CLR_BIT);
endpackage

// File: rtl/useq_seq.sv
`timescale 1ns/1ps
module useq_seq import useq_pkg::*; (
  input  logic              clk,
  input  logic              hardRst,
  input  logic [OP_W-1:0]   dataBus,
  input  logic [FLAG_W-1:0] flags,
  input  logic [INT_W-1:0]  intr,
  input  strobe_t           strobes,
  output uaddr_t            uAddr
);
  logic [OP_W-1:0]   instr;
  logic [STEP_W-1:0] step;
  logic              stepClrAll;

  assign stepClrAll = hardRst | strobes.stepClr;

  // opcode register: rising edge, load-enabled, asynchronous clear
  always_ff @(posedge clk or posedge hardRst) begin
    if (hardRst) instr <= '0;
    else if (strobes.irLoad) instr <= dataBus;
  end

  // step counter: falling edge, cleared at once by reset or microcode
  always_ff @(negedge clk or posedge stepClrAll) begin
    if (stepClrAll) step <= '0;
    else step <= step + STEP_W'(1);
  end

  assign uAddr = {instr, flags, intr, step};

  // marks a reset seen since the previous rising edge (assertion support)
  logic rstMark;
  always_ff @(posedge clk or posedge hardRst) begin
    if (hardRst) rstMark <= 1'b1;
    else rstMark <= 1'b0;
  end

  // R2 and R11: one step per falling edge, wrapping, unless cleared
  a_r2_step_advance: assert property (@(posedge clk) disable iff (hardRst)
    !rstMark |-> ((step == STEP_W'($past(step) + STEP_W'(1))) || (step == '0)));

  // R3: a clear seen at a rising edge has already zeroed the counter
  a_r3_clear_zero: assert property (@(posedge clk) disable iff (hardRst)
    strobes.stepClr |-> (step == '0));

  // R4: load takes the bus value, otherwise hold
  a_r4_load: assert property (@(posedge clk) disable iff (hardRst)
    (!rstMark && $past(strobes.irLoad)) |-> (instr == $past(dataBus)));
  a_r4_hold: assert property (@(posedge clk) disable iff (hardRst)
    (!rstMark && !$past(strobes.irLoad)) |-> $stable(instr));

  // R5: held reset keeps opcode and step at zero
  a_r5_reset_clears: assert property (@(posedge clk)
    (hardRst && $past(hardRst)) |-> ((instr == '0) && (step == '0)));
endmodule

// File: rtl/useq_rom.sv
`timescale 1ns/1ps
module useq_rom import useq_pkg::*; #(
  parameter int ROWS = 4,
  parameter logic [ROWS*ROW_W-1:0] TABLE = '0
) (
  input  uaddr_t uAddr,
  output word_t  word
);
  logic [ROWS-1:0] hit;
  word_t           rowWord [ROWS];

  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      localparam logic [ROW_W-1:0] ROW   = TABLE[r*ROW_W +: ROW_W];
      localparam uaddr_t           MATCH = ROW[WORD_W+ADDR_W +: ADDR_W];
      localparam uaddr_t           CARE  = ROW[WORD_W +: ADDR_W];
      localparam logic             VALID = ROW[ROW_W-1];
      assign hit[r]     = VALID && (((uAddr ^ MATCH) & CARE) == '0);
      assign rowWord[r] = ROW[WORD_W-1:0];
    end
  endgenerate

  // lowest hitting row wins; no hit gives the idle word
  always_comb begin
    word = IDLE_WORD;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (hit[r]) word = rowWord[r];
    end
  end
endmodule

// File: rtl/useq_dec.sv
`timescale 1ns/1ps
module useq_dec import useq_pkg::*; (
  input  word_t              word,
  output word_t              ctlRaw,
  output logic [NUM_SRC-1:0] busEn,
  output logic [NUM_WRS-1:0] wrSel,
  output strobe_t            strobes
);
  logic [SRC_W-1:0] srcCode;
  logic [WRS_W-1:0] wrCode;

  assign srcCode = word[SRC_LSB +: SRC_W];
  assign wrCode  = word[WRS_LSB +: WRS_W];
  assign ctlRaw  = word;

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign busEn[s] = (srcCode == SRC_W'(s));
    end
    for (genvar w = 0; w < NUM_WRS; w++) begin : g_wrs
      assign wrSel[w] = (wrCode == WRS_W'(w));
    end
  endgenerate

  assign strobes.irLoad  = word[LOAD_BIT];
  assign strobes.stepClr = word[CLR_BIT];
endmodule

// File: rtl/useq_top.sv
`timescale 1ns/1ps
module useq_top import useq_pkg::*; #(
  parameter int ROWS = 4,
  parameter logic [ROWS*ROW_W-1:0] TABLE = '0
) (
  input  logic         clk,
  input  logic         hardRst,
  input  logic [7:0]   dataBus,
  input  logic [3:0]   flags,
  input  logic [1:0]   intr,
  output logic [47:0]  ctlRaw,
  output logic [14:0]  busEn,
  output logic [7:0]   wrSel
);
  uaddr_t  uAddr;
  word_t   word;
  strobe_t strobes;

  useq_seq u_seq (
    .clk     (clk),
    .hardRst (hardRst),
    .dataBus (dataBus),
    .flags   (flags),
    .intr    (intr),
    .strobes (strobes),
    .uAddr   (uAddr)
  );

  useq_rom #(.ROWS(ROWS), .TABLE(TABLE)) u_rom (
    .uAddr (uAddr),
    .word  (word)
  );

  useq_dec u_dec (
    .word    (word),
    .ctlRaw  (ctlRaw),
    .busEn   (busEn),
    .wrSel   (wrSel),
    .strobes (strobes)
  );

  // R8: at most one bus source, none for the reserved code
  a_r8_one_source: assert property (@(posedge clk) disable iff (hardRst)
    $countones(busEn) == ((ctlRaw[SRC_LSB +: SRC_W] != SRC_NONE) ? 1 : 0));

  // R9: exactly one write/select line
  a_r9_one_write: assert property (@(posedge clk) disable iff (hardRst)
    $countones(wrSel) == 1);
endmodule

// File: tb/useq_top_test.sv
`timescale 1ns/1ps
module useq_top_test;
  import useq_pkg::*;

  localparam int NROWS = 11;

  function automatic word_t mk(input logic [7:0] sig, input logic [3:0] src,
                               input logic [2:0] wr, input logic clr, input logic ld);
    word_t w;
    w = '0;
    w[3:0]   = src;
    w[6:4]   = wr;
    w[7]     = clr;
    w[8]     = ld;
    w[17:10] = sig;
    w[47]    = ld;
    return w;
  endfunction

  function automatic logic [ROW_W-1:0] mkRow(
      input logic [7:0] opM, input logic [7:0] opC,
      input logic [3:0] flM, input logic [3:0] flC,
      input logic [1:0] itM, input logic [1:0] itC,
      input logic [3:0] stM, input logic [3:0] stC, input word_t w);
    return {1'b1, opM, flM, itM, stM, opC, flC, itC, stC, w};
  endfunction

  localparam word_t W0   = mk(8'h01, 4'd2,  3'd1, 1'b0, 1'b0); // soft reset step 0
  localparam word_t W1   = mk(8'h02, 4'd15, 3'd0, 1'b0, 1'b1); // soft reset step 1, no source
  localparam word_t W2   = mk(8'h10, 4'd0,  3'd0, 1'b0, 1'b1); // common fetch
  localparam word_t W31  = mk(8'h31, 4'd6,  3'd5, 1'b0, 1'b0);
  localparam word_t W3F  = mk(8'h3F, 4'd14, 3'd7, 1'b0, 1'b0);
  localparam word_t W2A  = mk(8'h2A, 4'd7,  3'd6, 1'b0, 1'b0);
  localparam word_t W3   = mk(8'h21, 4'd3,  3'd2, 1'b0, 1'b0);
  localparam word_t W4   = mk(8'h22, 4'd4,  3'd3, 1'b0, 1'b0);
  localparam word_t W5   = mk(8'h23, 4'd5,  3'd4, 1'b0, 1'b0);
  localparam word_t W6   = mk(8'h5A, 4'd1,  3'd1, 1'b1, 1'b0); // explicit end
  localparam word_t W30  = mk(8'h30, 4'd8,  3'd0, 1'b0, 1'b0);

  function automatic logic [NROWS*ROW_W-1:0] buildTable();
    logic [NROWS*ROW_W-1:0] t;
    t = '0;
    t[0*ROW_W  +: ROW_W] = mkRow(8'h00, 8'hFF, 4'h0, 4'h0, 2'b00, 2'b00, 4'd0,  4'hF, W0);
    t[1*ROW_W  +: ROW_W] = mkRow(8'h00, 8'hFF, 4'h0, 4'h0, 2'b00, 2'b00, 4'd1,  4'hF, W1);
    t[2*ROW_W  +: ROW_W] = mkRow(8'h3C, 8'hFF, 4'h0, 4'h0, 2'b00, 2'b00, 4'd0,  4'hF, W31);
    t[3*ROW_W  +: ROW_W] = mkRow(8'h3C, 8'hFF, 4'h0, 4'h0, 2'b00, 2'b00, 4'd15, 4'hF, W3F);
    t[4*ROW_W  +: ROW_W] = mkRow(8'h00, 8'h00, 4'h0, 4'h0, 2'b00, 2'b00, 4'd0,  4'hF, W2);
    t[5*ROW_W  +: ROW_W] = mkRow(8'hA5, 8'hFF, 4'h0, 4'h0, 2'b01, 2'b11, 4'd1,  4'hF, W2A);
    t[6*ROW_W  +: ROW_W] = mkRow(8'hA5, 8'hFF, 4'h0, 4'h0, 2'b00, 2'b00, 4'd1,  4'hF, W3);
    t[7*ROW_W  +: ROW_W] = mkRow(8'hA5, 8'hFF, 4'h8, 4'h8, 2'b00, 2'b00, 4'd2,  4'hF, W4);
    t[8*ROW_W  +: ROW_W] = mkRow(8'hA5, 8'hFF, 4'h0, 4'h0, 2'b00, 2'b00, 4'd2,  4'hF, W5);
    t[9*ROW_W  +: ROW_W] = mkRow(8'h5A, 8'hFF, 4'h0, 4'h0, 2'b00, 2'b00, 4'd1,  4'hF, W6);
    t[10*ROW_W +: ROW_W] = mkRow(8'h3C, 8'hFF, 4'h0, 4'h0, 2'b00, 2'b00, 4'd0,  4'h0, W30);
    return t;
  endfunction

  localparam logic [NROWS*ROW_W-1:0] PROG = buildTable();

  logic        clk = 1'b0;
  logic        hardRst = 1'b1;
  logic [7:0]  dataBus = '0;
  logic [3:0]  flags = '0;
  logic [1:0]  intr = '0;
  logic [47:0] ctlRaw;
  logic [14:0] busEn;
  logic [7:0]  wrSel;

  useq_top #(.ROWS(NROWS), .TABLE(PROG)) uut (
    .clk     (clk),
    .hardRst (hardRst),
    .dataBus (dataBus),
    .flags   (flags),
    .intr    (intr),
    .ctlRaw  (ctlRaw),
    .busEn   (busEn),
    .wrSel   (wrSel)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    word_t word;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  // driver: set inputs just after a rising edge, queue the word due this cycle
  // rm: 0 = reset low, 1 = reset held, 2 = short reset pulse before the falling edge
  task automatic cyc(input logic [7:0] bus, input logic [3:0] fl, input logic [1:0] it,
                     input int rm, input word_t expWord, input string tag);
    exp_t e;
    @(posedge clk);
    #0.5;
    dataBus = bus;
    flags   = fl;
    intr    = it;
    hardRst = (rm == 1);
    e.word = expWord;
    e.tag  = tag;
    q.push_back(e);
    if (rm == 2) begin
      hardRst = 1'b1;
      #1;
      hardRst = 1'b0;
    end
  endtask

  // monitor: sample late in the low phase, before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        logic [14:0] expBus;
        logic [7:0]  expWr;
        e = q.pop_front();
        expBus = (e.word[3:0] == 4'hF) ? 15'd0 : (15'd1 << e.word[3:0]);
        expWr  = 8'd1 << e.word[6:4];
        checks++;
        if (ctlRaw !== e.word) begin
          failures++;
          $display("FAIL %s R10 ctlRaw actual=%h expected=%h", e.tag, ctlRaw, e.word);
        end
        checks++;
        if (busEn !== expBus) begin
          failures++;
          $display("FAIL %s R8 busEn actual=%h expected=%h", e.tag, busEn, expBus);
        end
        checks++;
        if (wrSel !== expWr) begin
          failures++;
          $display("FAIL %s R9 wrSel actual=%h expected=%h", e.tag, wrSel, expWr);
        end
      end
    end
  end

  initial begin
    #(5.0 * 2000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R5: held reset gives opcode 0x00 step 0, step frozen
    cyc(8'h00, 4'h0, 2'b00, 1, W0,  "R5 reset state");
    cyc(8'h00, 4'hF, 2'b11, 1, W0,  "R5 R6 reset held, flags ignored");
    // R2: release, counter steps to 1 (no-source code 15, R8)
    cyc(8'hA5, 4'hF, 2'b11, 0, W1,  "R2 R6 opcode 0 step 1 under flags");
    // R4: opcode loaded from the bus; R6 zero-flag row beats the fallback
    cyc(8'h00, 4'h8, 2'b00, 0, W4,  "R4 R6 zero-flag priority");
    // R7: unprogrammed step 3 returns to fetch in the same cycle
    cyc(8'hA5, 4'h0, 2'b00, 0, W2,  "R7 unprogrammed step to fetch");
    cyc(8'h00, 4'h0, 2'b01, 0, W2A, "R1 R6 interrupt request row");
    cyc(8'h00, 4'h7, 2'b00, 0, W5,  "R6 fallback row, zero flag clear");
    cyc(8'h5A, 4'h0, 2'b00, 0, W2,  "R7 fetch after unprogrammed step");
    // R3: explicit clear word at step 1 of 0x5A never reaches the sample
    cyc(8'hA5, 4'h0, 2'b00, 0, W2,  "R3 explicit clear to fetch");
    cyc(8'h00, 4'h0, 2'b00, 0, W3,  "R1 distinct opcode at step 1");
    cyc(8'h00, 4'h8, 2'b00, 0, W4,  "R6 zero-flag row again");
    cyc(8'h3C, 4'h0, 2'b00, 0, W2,  "R7 fetch of 0x3C");
    cyc(8'hA5, 4'h0, 2'b00, 0, W30, "R1 opcode 0x3C step 1");
    for (int k = 0; k < 13; k++) begin
      cyc(8'hA5, 4'h0, 2'b00, 0, W30, "R2 R4 counting, register held");
    end
    cyc(8'hA5, 4'h0, 2'b00, 0, W3F, "R11 step 15");
    cyc(8'hA5, 4'h0, 2'b00, 0, W31, "R11 wrap to step 0");
    cyc(8'hA5, 4'h0, 2'b00, 0, W30, "R2 step 1 after wrap");
    // R5: short pulse between edges clears opcode and step without a clock
    cyc(8'hA5, 4'h0, 2'b00, 2, W1,  "R5 asynchronous reset pulse");
    cyc(8'h00, 4'h8, 2'b00, 0, W4,  "R4 load after soft reset step");
    cyc(8'h00, 4'h0, 2'b00, 0, W2,  "R7 R10 end to fetch");
    @(posedge clk);
    @(posedge clk);
    wait (q.size() == 0);
    @(posedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule